// File: doc/BRIEF.md
# Masked Multi-Address Slave Matcher

This block decides whether an I2C target should answer the address byte that a master has just sent. It holds four own 7-bit addresses. Each has its own don't-care mask and its own general-call enable. A register port writes and reads these settings and a small control word. The control word holds the acknowledge-enable bit and the master-mode flag, and it accepts a one-shot stop request.

Bit-level reception happens elsewhere. The receiver hands this block the captured byte and a one-cycle strobe. One cycle later the block reports five results:
- whether the byte matched;
- which entry matched;
- whether the match was a general call;
- the read/write bit;
- whether the target should acknowledge.

It also keeps an "addressed" flag. The flag is set when an address is acknowledged and cleared by a stop request made in slave mode.

Top module: `slave_addr_match`

## Requirements
- R1: While `rst_n` is low and after reset, all own addresses, masks, general-call enables and control bits are 0. All result outputs and `addressed` are 0.
- R2: The register port decodes `reg_sel` as follows. Selects 0..3 hold entry i as {address[7:1], general-call enable[0]}. Selects 4..7 hold the mask of entry i-4 in bits 7:1; bit 0 reads as 0. Select 8 is control: bit 0 is acknowledge-enable, bit 1 is master mode, and bit 2 is a stop request that reads as 0. Every other select reads 0 and ignores writes. `reg_rdata` is combinational from the stored state.
- R3: A strobe sampled on a clock edge produces a one-cycle `match_valid` pulse right after that edge. The other results are updated at the same edge and hold until the next strobe. `rw_bit` equals bit 0 of the byte, and that bit takes no part in the comparison.
- R4: For a nonzero received address, entry i matches when every bit of byte[7:1] equals its own-address bit, except bits whose mask bit is 1, which are ignored.
- R5: `match_hit` is 1 when any entry matches. `match_idx` is the lowest-numbered matching entry, or 0 when nothing matches.
- R6: A received 7-bit address of 0 matches only through general call. It matches entry i only when that entry's general-call enable is 1, and never through the address compare. `gc_hit` is 1 for such a match.
- R7: In master mode the stored addresses are ignored. A strobe gives `match_hit`, `gc_hit` and `match_ack` of 0 and does not change `addressed`.
- R8: `match_ack` (1 means drive ACK, 0 means leave SDA high) equals `match_hit` AND the acknowledge-enable bit as it stood when the strobe was sampled. A hit with acknowledge-enable 0 is reported with `match_ack` 0.
- R9: `addressed` is set after an acknowledged strobe. Writing control with bit 2 set clears it when master mode is 0 before the write, and the clear wins over a set in the same cycle. In master mode the stop request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| addr_stb | input | 1 | Address byte valid strobe |
| addr_byte | input | 8 | Received byte: address in 7:1, R/W in 0 |
| match_valid | output | 1 | One-cycle result pulse |
| match_hit | output | 1 | Some entry matched (slave mode) |
| match_idx | output | 2 | Lowest matching entry |
| gc_hit | output | 1 | Match was a general call |
| rw_bit | output | 1 | Captured R/W bit |
| match_ack | output | 1 | Acknowledge decision |
| addressed | output | 1 | Target is addressed |

## Verification
Every match result and the `addressed` flag is due one clock after the edge that samples the strobe or the register write. `reg_rdata` is due in the same cycle as the select, after the registers update.

The bench drives its inputs on falling edges. It advances a behavioural model on each rising edge, using the register values held before that edge, and compares every output against the model on the next falling edge. A hit, an acknowledge or a stop therefore counts only if it lands in exactly the cycle the model predicts. Directed cases cover overlapping entries, masks, general call, acknowledge-enable off and master mode. A long random phase then mixes register writes with strobes in the same cycle.

// File: rtl/slave_addr_match.sv
module slave_addr_match #(
  parameter int N_ENTRY = 4,
  parameter int SEL_W   = 4,
  parameter int IDX_W   = $clog2(N_ENTRY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             addr_stb,
  input  logic [7:0]       addr_byte,
  output logic             match_valid,
  output logic             match_hit,
  output logic [IDX_W-1:0] match_idx,
  output logic             gc_hit,
  output logic             rw_bit,
  output logic             match_ack,
  output logic             addressed
);
  localparam int CTL_SEL = 2 * N_ENTRY;

  logic [6:0]         own_q [N_ENTRY];
  logic [6:0]         msk_q [N_ENTRY];
  logic [N_ENTRY-1:0] gc_q;
  logic               aa_q, master_q;

  logic [6:0]         rx_addr;
  logic               rx_zero;
  logic [N_ENTRY-1:0] ent_hit;
  logic [IDX_W-1:0]   pick_idx;
  logic               hit_now, ack_now, ctl_wr, stop_req;

  assign rx_addr  = addr_byte[7:1];
  assign rx_zero  = (rx_addr == 7'd0);
  assign ctl_wr   = reg_we && (reg_sel == SEL_W'(CTL_SEL));
  assign stop_req = ctl_wr && reg_wdata[2] && !master_q;

  for (genvar i = 0; i < N_ENTRY; i++) begin : g_ent
    assign ent_hit[i] = rx_zero ? gc_q[i]
                                : (((rx_addr ^ own_q[i]) & ~msk_q[i]) == 7'd0);
  end

  always_comb begin
    pick_idx = '0;
    for (int i = N_ENTRY - 1; i >= 0; i--)
      if (ent_hit[i]) pick_idx = IDX_W'(i);
  end

  assign hit_now = (|ent_hit) && !master_q;
  assign ack_now = hit_now && aa_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENTRY; i++) begin
        own_q[i] <= '0;
        msk_q[i] <= '0;
      end
      gc_q     <= '0;
      aa_q     <= 1'b0;
      master_q <= 1'b0;
    end else if (reg_we) begin
      for (int i = 0; i < N_ENTRY; i++) begin
        if (reg_sel == SEL_W'(i)) begin
          own_q[i] <= reg_wdata[7:1];
          gc_q[i]  <= reg_wdata[0];
        end
        if (reg_sel == SEL_W'(N_ENTRY + i))
          msk_q[i] <= reg_wdata[7:1];
      end
      if (ctl_wr) begin
        aa_q     <= reg_wdata[0];
        master_q <= reg_wdata[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_valid <= 1'b0;
      match_hit   <= 1'b0;
      match_idx   <= '0;
      gc_hit      <= 1'b0;
      rw_bit      <= 1'b0;
      match_ack   <= 1'b0;
      addressed   <= 1'b0;
    end else begin
      match_valid <= addr_stb;
      if (addr_stb) begin
        match_hit <= hit_now;
        match_idx <= hit_now ? pick_idx : '0;
        gc_hit    <= hit_now && rx_zero;
        rw_bit    <= addr_byte[0];
        match_ack <= ack_now;
      end
      if (stop_req)
        addressed <= 1'b0;
      else if (addr_stb && ack_now)
        addressed <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N_ENTRY; i++) begin
      if (reg_sel == SEL_W'(i))           reg_rdata = {own_q[i], gc_q[i]};
      if (reg_sel == SEL_W'(N_ENTRY + i)) reg_rdata = {msk_q[i], 1'b0};
    end
    if (reg_sel == SEL_W'(CTL_SEL)) reg_rdata = {6'd0, master_q, aa_q};
  end
endmodule

// File: rtl/slave_addr_match_chk.sv
module slave_addr_match_chk #(
  parameter int N_ENTRY = 4,
  parameter int SEL_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [SEL_W-1:0] reg_sel,
  input logic [7:0]       reg_wdata,
  input logic             addr_stb,
  input logic [7:0]       addr_byte,
  input logic             aa_q,
  input logic             master_q,
  input logic             match_valid,
  input logic             match_hit,
  input logic             gc_hit,
  input logic             rw_bit,
  input logic             match_ack,
  input logic             addressed
);
  AST_VALID_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(addr_stb) |-> match_valid); // R3
  AST_RW_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> rw_bit == $past(addr_byte[0])); // R3
  AST_ACK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    match_ack |-> match_hit); // R8
  AST_ACK_GATED_BY_AA: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && !$past(aa_q)) |-> !match_ack); // R8
  AST_MASTER_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && $past(master_q)) |-> !match_hit); // R7
  AST_GC_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && gc_hit) |-> $past(addr_byte[7:1]) == 7'd0); // R6
  AST_ADDRESSED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> (match_valid && match_ack)); // R9
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_sel == SEL_W'(2 * N_ENTRY) && reg_wdata[2] && !master_q)
      |-> !addressed); // R9
endmodule

bind slave_addr_match slave_addr_match_chk #(.N_ENTRY(N_ENTRY), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .addr_stb(addr_stb), .addr_byte(addr_byte), .aa_q(aa_q), .master_q(master_q),
  .match_valid(match_valid), .match_hit(match_hit), .gc_hit(gc_hit), .rw_bit(rw_bit),
  .match_ack(match_ack), .addressed(addressed)
);

// File: tb/slave_addr_match_test.sv
module slave_addr_match_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, addr_stb = 1'b0;
  logic [3:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0, addr_byte = '0, reg_rdata;
  logic match_valid, match_hit, gc_hit, rw_bit, match_ack, addressed;
  logic [1:0] match_idx;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  int m_own[4], m_msk[4], m_gc[4];
  int m_aa, m_mst, m_addr;
  int e_valid, e_hit, e_idx, e_gc, e_rw, e_ack;

  always #5 clk = ~clk;

  slave_addr_match uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .addr_stb(addr_stb), .addr_byte(addr_byte),
    .match_valid(match_valid), .match_hit(match_hit), .match_idx(match_idx),
    .gc_hit(gc_hit), .rw_bit(rw_bit), .match_ack(match_ack), .addressed(addressed)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int rd_model(int sel);
    if (sel < 4) return (m_own[sel] << 1) | m_gc[sel];
    if (sel < 8) return m_msk[sel-4] << 1;
    if (sel == 8) return (m_mst << 1) | m_aa;
    return 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_own[i] = 0; m_msk[i] = 0; m_gc[i] = 0; end
      m_aa = 0; m_mst = 0; m_addr = 0;
      e_valid = 0; e_hit = 0; e_idx = 0; e_gc = 0; e_rw = 0; e_ack = 0;
    end else begin
      int rx, best, ack;
      ack = 0;
      e_valid = addr_stb;
      if (addr_stb) begin
        rx = int'(addr_byte) >> 1;
        best = -1;
        for (int i = 3; i >= 0; i--) begin
          if (rx == 0) begin
            if (m_gc[i] != 0) best = i;
          end else if (((rx ^ m_own[i]) & ~m_msk[i] & 127) == 0) best = i;
        end
        if (m_mst != 0) best = -1;
        e_hit = (best >= 0);
        e_idx = (best >= 0) ? best : 0;
        e_gc  = (best >= 0) && (rx == 0);
        e_rw  = addr_byte[0];
        ack   = e_hit && (m_aa != 0);
        e_ack = ack;
        if (ack) m_addr = 1;
      end
      if (reg_we) begin
        if (reg_sel < 4) begin m_own[reg_sel] = reg_wdata >> 1; m_gc[reg_sel] = reg_wdata[0]; end
        else if (reg_sel < 8) m_msk[reg_sel-4] = reg_wdata >> 1;
        else if (reg_sel == 8) begin
          if (reg_wdata[2] && m_mst == 0) m_addr = 0;
          m_aa = reg_wdata[0]; m_mst = reg_wdata[1];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R3 match_valid", match_valid, e_valid);
      chk("R5 match_hit", match_hit, e_hit);
      chk("R5 match_idx", match_idx, e_idx);
      chk("R6 gc_hit", gc_hit, e_gc);
      chk("R3 rw_bit", rw_bit, e_rw);
      chk("R8 match_ack", match_ack, e_ack);
      chk("R9 addressed", addressed, m_addr);
      chk("R2 reg_rdata", reg_rdata, rd_model(reg_sel));
    end
  end

  task automatic wr(int sel, int data);
    reg_we = 1'b1; reg_sel = 4'(sel); reg_wdata = 8'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic stb(int addr7, int rw);
    addr_stb = 1'b1; addr_byte = 8'((addr7 << 1) | rw);
    @(negedge clk);
    addr_stb = 1'b0;
    reg_sel = 4'($urandom_range(0, 11));
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state observed on the ports, all selects read 0
    for (int s = 0; s < 12; s++) begin reg_sel = 4'(s); @(negedge clk); end
    rst_n = 1'b1;
    @(negedge clk);
    // R2, R4: entries and masks; entry 1 ignores address bits 1:0
    wr(0, 8'hA0); wr(1, 8'hA4); wr(2, 8'h78); wr(3, 8'h20);
    wr(5, 8'h06); wr(9, 8'hFF);
    wr(8, 8'h05); // R2: stop bit reads back 0
    for (int s = 0; s < 12; s++) begin reg_sel = 4'(s); @(negedge clk); end
    stb(7'h50, 0);  // R5: entries 0 and 1 match, lowest is 0
    stb(7'h53, 1);  // R4: masked match on entry 1
    stb(7'h3C, 0);
    stb(7'h3D, 1);  // no match
    stb(7'h10, 1);
    stb(7'h00, 0);  // R6: no general call enabled
    wr(3, 8'h21); stb(7'h00, 1);  // R6: general call on entry 3
    wr(1, 8'hA5); stb(7'h00, 0);  // R6: lowest general-call entry is 1
    wr(8, 8'h04);                 // R9: stop clears addressed
    wr(8, 8'h00); stb(7'h3C, 0);  // R8: hit without acknowledge
    wr(8, 8'h01); stb(7'h3C, 0);  // R9: addressed set
    wr(8, 8'h03); wr(8, 8'h07);   // R9: stop ignored in master mode
    stb(7'h3C, 0); stb(7'h00, 1); // R7: master mode, no hit
    wr(8, 8'h05);
    // same-cycle strobe and stop: clear wins (R9)
    wr(8, 8'h01); stb(7'h50, 0);
    addr_stb = 1'b1; addr_byte = 8'hA0; reg_we = 1'b1; reg_sel = 4'd8; reg_wdata = 8'h05;
    @(negedge clk);
    addr_stb = 1'b0; reg_we = 1'b0;
    @(negedge clk);
    // random mix of writes and strobes
    for (int k = 0; k < 3000; k++) begin
      addr_stb  = 1'($urandom_range(0, 1));
      addr_byte = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 1)) : 8'($urandom);
      reg_we    = ($urandom_range(0, 3) == 0);
      reg_sel   = 4'($urandom_range(0, 10));
      reg_wdata = 8'($urandom);
      if (reg_sel == 4'd8 && $urandom_range(0, 1) == 1) reg_wdata[1] = 1'b0;
      @(negedge clk);
    end
    addr_stb = 1'b0; reg_we = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule